// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small translation buffer that sits between a core's address generation and a physically addressed cache. Each lookup presents a virtual address, the current address-space identifier (ASID), the kind of access and the privilege level. One clock later the buffer answers with one of four outcomes:

- a hit, together with the physical address;
- a miss;
- a protection fault;
- a dirty-update miss, which asks software to mark the page as modified.

Misses are only reported. A separate fill port loads a whole translation, and the page-table walk that produces it lives outside this block.

Every entry is tagged with an ASID, so translations from several processes can stay resident across context switches. Pages are 8 KB, and the low 13 address bits pass straight through. Any translation may occupy any slot. When no slot is free, the slot to evict is picked pseudo-randomly, but the slot touched most recently is never picked. Software can invalidate the whole buffer, or only one ASID's entries, in a single cycle.

Top module: `tlbAsid`

## Requirements
- R1: The buffer holds 32 entries, placement is fully associative, and 32 distinct translations filled after an invalidate are all resident at the same time.
- R2: A lookup issued on a clock edge is answered on the next edge with `respValid`=1. A match needs a valid entry whose virtual page number and ASID both equal the request's. With no match, hit, fault and dirty are all 0. `respValid` is 0 in any cycle that answers no lookup.
- R3: On a hit, `respPa` is the entry's physical page number followed by request address bits [12:0]. Whenever the answer is not a hit, `respPa` is 0.
- R4: Access codes are 0 read, 1 write and 2 fetch. Permission codes are 0 read-only, 1 read-write, 2 fetch-only and 3 none. An access that the matched entry's permission code does not allow gives `respFault`=1 instead of a hit.
- R5: When `lookupKernel`=0, a matched entry with its user flag clear gives `respFault`=1. Kernel-mode accesses ignore the user flag.
- R6: A permitted write that matches an entry with its dirty flag clear gives `respDirty`=1 and no hit. A fault takes precedence over a dirty-update miss.
- R7: A fill whose page number and ASID match a valid entry overwrites that entry in place. Otherwise the fill goes to the lowest-numbered invalid slot. When every slot is valid, exactly one entry is evicted, chosen pseudo-randomly.
- R8: A random eviction never picks the most recently used slot. That slot is the one written by the latest fill or matched by the latest lookup; when both happen in the same cycle, the fill counts.
- R9: A full invalidate clears every entry in one cycle.
- R10: An ASID invalidate clears only the entries tagged with that ASID, in one cycle, and leaves every other entry resident.
- R11: A fill in the same cycle as either invalidate is discarded. A lookup in the same cycle as a fill or an invalidate sees the contents from before that cycle.
- R12: At most one of hit, fault and dirty is set, and all three are 0 when `respValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupVa | input | 43 | Virtual address to translate |
| lookupAsid | input | 8 | ASID of the running process |
| lookupAccess | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lookupKernel | input | 1 | 1 when the request comes from kernel mode |
| fillValid | input | 1 | Fill request strobe |
| fillVpn | input | 30 | Virtual page number of the new translation |
| fillAsid | input | 8 | ASID of the new translation |
| fillPpn | input | 21 | Physical page number of the new translation |
| fillPerm | input | 2 | Permission: 0 read-only, 1 read-write, 2 fetch-only, 3 none |
| fillUser | input | 1 | 1 when user mode may access the page |
| fillDirty | input | 1 | Initial dirty flag |
| flushAll | input | 1 | Invalidate every entry |
| flushAsidValid | input | 1 | Invalidate the entries of one ASID |
| flushAsid | input | 8 | ASID to invalidate |
| respValid | output | 1 | Answer to the previous cycle's lookup |
| respHit | output | 1 | Translation succeeded |
| respFault | output | 1 | Matched entry forbids this access |
| respDirty | output | 1 | Write to a clean page, software update needed |
| respPa | output | 34 | Physical address on a hit, else 0 |

## Verification
The assertions assume that every request input is held low while reset is asserted. The invalidate property relies on this when it looks one cycle back just after reset. They also assume that access code 3 is never presented. The bench drives inputs only from idle values it restores after each operation, and it issues no lookup until reset has been released. Random evictions are checked without predicting the generator: after each replacing fill, the bench probes every resident page, expects exactly one to be missing, and requires that this is not the slot it had just touched.

// File: rtl/tlbPkg.sv
`timescale 1ns/1ps
package tlbPkg;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} accessT;
  typedef enum logic [1:0] {PERM_RO = 2'd0, PERM_RW = 2'd1, PERM_XO = 2'd2, PERM_NONE = 2'd3} permT;

  // strobes from control to the entry datapath
  typedef struct packed {
    logic fillEn;
    logic flushAll;
    logic flushAsid;
    logic lookupEn;
  } tlbStrobeT;
endpackage

// File: rtl/tlbCtrl.sv
`timescale 1ns/1ps
module tlbCtrl
  import tlbPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               fillValid,
  input  logic               flushAllReq,
  input  logic               flushAsidReq,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  input  logic [ENTRIES-1:0] lookupMatchVec,
  output tlbStrobeT          stb,
  output logic [IDX_W-1:0]   fillIdx
);
  localparam int LFSR_W = 16;

  logic [LFSR_W-1:0] lfsr;
  logic [IDX_W-1:0]  lastUsed;
  logic [IDX_W-1:0]  freeIdx, matchIdx, lookIdx, randRaw, randIdx;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // free-running maximal-length generator (taps 16,14,13,11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_W'(1);
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  assign freeIdx  = lowestSet(~validVec);
  assign matchIdx = lowestSet(fillMatchVec);
  assign lookIdx  = lowestSet(lookupMatchVec);
  assign randRaw  = lfsr[IDX_W-1:0];
  // entry count is a power of two, so the increment wraps inside the array
  assign randIdx  = (randRaw == lastUsed) ? randRaw + 1'b1 : randRaw;

  always_comb begin
    if (|fillMatchVec)   fillIdx = matchIdx;
    else if (~&validVec) fillIdx = freeIdx;
    else                 fillIdx = randIdx;
  end

  always_comb begin
    stb.flushAll  = flushAllReq;
    stb.flushAsid = flushAsidReq;
    stb.fillEn    = fillValid && !flushAllReq && !flushAsidReq;
    stb.lookupEn  = lookupValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 lastUsed <= '0;
    else if (stb.fillEn)                       lastUsed <= fillIdx;
    else if (lookupValid && |lookupMatchVec)   lastUsed <= lookIdx;
  end
endmodule

// File: rtl/tlbDatapath.sv
`timescale 1ns/1ps
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int VPN_W     = 30,
  parameter int PPN_W     = 21,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 13,
  parameter int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tlbStrobeT                  stb,
  input  logic [IDX_W-1:0]           fillIdx,
  input  logic [VPN_W-1:0]           lookupVpn,
  input  logic [PAGE_BITS-1:0]       lookupOff,
  input  logic [ASID_W-1:0]          lookupAsid,
  input  logic [1:0]                 lookupAccess,
  input  logic                       lookupKernel,
  input  logic [VPN_W-1:0]           fillVpn,
  input  logic [ASID_W-1:0]          fillAsid,
  input  logic [PPN_W-1:0]           fillPpn,
  input  logic [1:0]                 fillPerm,
  input  logic                       fillUser,
  input  logic                       fillDirty,
  input  logic [ASID_W-1:0]          flushAsidVal,
  output logic [ENTRIES-1:0]         validVec,
  output logic [ENTRIES-1:0]         fillMatchVec,
  output logic [ENTRIES-1:0]         lookupMatchVec,
  output logic                       respValid,
  output logic                       respHit,
  output logic                       respFault,
  output logic                       respDirty,
  output logic [PPN_W+PAGE_BITS-1:0] respPa
);
  logic [ENTRIES-1:0]             entValid, entUser, entDirty, asidMatchVec;
  logic [ENTRIES-1:0][VPN_W-1:0]  entVpn;
  logic [ENTRIES-1:0][ASID_W-1:0] entAsid;
  logic [ENTRIES-1:0][PPN_W-1:0]  entPpn;
  logic [ENTRIES-1:0][1:0]        entPerm;

  logic [PPN_W-1:0] selPpn;
  logic [1:0]       selPerm;
  logic             selUser, selDirty, anyMatch, permOk, privOk, allowed;
  logic             nextHit, nextFault, nextDirty;

  // parallel comparators, one set per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lookupMatchVec[g] = entValid[g] && entVpn[g] == lookupVpn && entAsid[g] == lookupAsid;
    assign fillMatchVec[g]   = entValid[g] && entVpn[g] == fillVpn   && entAsid[g] == fillAsid;
    assign asidMatchVec[g]   = entAsid[g] == flushAsidVal;
  end
  assign validVec = entValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (stb.flushAll)                          entValid[i] <= 1'b0;
        else if (stb.flushAsid && asidMatchVec[i]) entValid[i] <= 1'b0;
        else if (stb.fillEn && fillIdx == IDX_W'(i)) entValid[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (stb.fillEn && fillIdx == IDX_W'(i)) begin
        entVpn[i]   <= fillVpn;
        entAsid[i]  <= fillAsid;
        entPpn[i]   <= fillPpn;
        entPerm[i]  <= fillPerm;
        entUser[i]  <= fillUser;
        entDirty[i] <= fillDirty;
      end
    end
  end

  // matches are unique, so an AND-OR select is enough
  always_comb begin
    selPpn   = '0;
    selPerm  = '0;
    selUser  = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupMatchVec[i]) begin
        selPpn   = selPpn | entPpn[i];
        selPerm  = selPerm | entPerm[i];
        selUser  = selUser | entUser[i];
        selDirty = selDirty | entDirty[i];
      end
    end
  end

  always_comb begin
    case (lookupAccess)
      ACC_READ:  permOk = (selPerm == PERM_RO) || (selPerm == PERM_RW);
      ACC_WRITE: permOk = (selPerm == PERM_RW);
      ACC_FETCH: permOk = (selPerm == PERM_XO);
      default:   permOk = 1'b0;
    endcase
  end

  assign anyMatch  = |lookupMatchVec;
  assign privOk    = lookupKernel || selUser;
  assign allowed   = permOk && privOk;
  assign nextFault = stb.lookupEn && anyMatch && !allowed;
  assign nextDirty = stb.lookupEn && anyMatch && allowed && lookupAccess == ACC_WRITE && !selDirty;
  assign nextHit   = stb.lookupEn && anyMatch && allowed && !nextDirty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respFault <= 1'b0;
      respDirty <= 1'b0;
      respPa    <= '0;
    end else begin
      respValid <= stb.lookupEn;
      respHit   <= nextHit;
      respFault <= nextFault;
      respDirty <= nextDirty;
      respPa    <= nextHit ? {selPpn, lookupOff} : '0;
    end
  end
endmodule

// File: rtl/tlbAsid.sv
`timescale 1ns/1ps
module tlbAsid
  import tlbPkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int VA_W      = 43,
  parameter int PA_W      = 34,
  parameter int PAGE_BITS = 13,
  parameter int ASID_W    = 8,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic [1:0]        lookupAccess,
  input  logic              lookupKernel,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [1:0]        fillPerm,
  input  logic              fillUser,
  input  logic              fillDirty,
  input  logic              flushAll,
  input  logic              flushAsidValid,
  input  logic [ASID_W-1:0] flushAsid,
  output logic              respValid,
  output logic              respHit,
  output logic              respFault,
  output logic              respDirty,
  output logic [PA_W-1:0]   respPa
);
  tlbStrobeT          stb;
  logic [IDX_W-1:0]   fillIdx;
  logic [ENTRIES-1:0] validVec, fillMatchVec, lookupMatchVec;

  tlbCtrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .fillValid(fillValid),
    .flushAllReq(flushAll), .flushAsidReq(flushAsidValid),
    .validVec(validVec), .fillMatchVec(fillMatchVec), .lookupMatchVec(lookupMatchVec),
    .stb(stb), .fillIdx(fillIdx)
  );

  tlbDatapath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W),
    .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .fillIdx(fillIdx),
    .lookupVpn(lookupVa[VA_W-1:PAGE_BITS]), .lookupOff(lookupVa[PAGE_BITS-1:0]),
    .lookupAsid(lookupAsid), .lookupAccess(lookupAccess), .lookupKernel(lookupKernel),
    .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .fillUser(fillUser), .fillDirty(fillDirty), .flushAsidVal(flushAsid),
    .validVec(validVec), .fillMatchVec(fillMatchVec), .lookupMatchVec(lookupMatchVec),
    .respValid(respValid), .respHit(respHit), .respFault(respFault),
    .respDirty(respDirty), .respPa(respPa)
  );
endmodule

// File: rtl/tlbAsidChecker.sv
`timescale 1ns/1ps
module tlbAsidChecker #(
  parameter int VA_W      = 43,
  parameter int PA_W      = 34,
  parameter int PAGE_BITS = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic [VA_W-1:0] lookupVa,
  input logic [1:0]      lookupAccess,
  input logic            flushAll,
  input logic            respValid,
  input logic            respHit,
  input logic            respFault,
  input logic            respDirty,
  input logic [PA_W-1:0] respPa
);
  assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid == $past(lookupValid));

  assert_outcome_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respHit, respFault, respDirty}));

  assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && !respFault && !respDirty && respPa == '0));

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respPa[PAGE_BITS-1:0] == $past(lookupVa[PAGE_BITS-1:0]));

  assert_dirty_on_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    respDirty |-> $past(lookupAccess) == 2'd1);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flushAll) && lookupValid) |=> (!respHit && !respFault && !respDirty));
endmodule

bind tlbAsid tlbAsidChecker #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVa(lookupVa),
  .lookupAccess(lookupAccess), .flushAll(flushAll), .respValid(respValid),
  .respHit(respHit), .respFault(respFault), .respDirty(respDirty), .respPa(respPa)
);

// File: tb/tb_tlbAsid.sv
`timescale 1ns/1ps
module tb_tlbAsid;
  localparam int N = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic lookupValid, lookupKernel, fillValid, fillUser, fillDirty, flushAll, flushAsidValid;
  logic [42:0] lookupVa;
  logic [7:0]  lookupAsid, fillAsid, flushAsid;
  logic [1:0]  lookupAccess, fillPerm;
  logic [29:0] fillVpn;
  logic [20:0] fillPpn;
  logic respValid, respHit, respFault, respDirty;
  logic [33:0] respPa;

  tlbAsid dut (.*);

  always #4 clk = ~clk;

  // behavioural model
  logic        mVal[N];
  logic [29:0] mVpn[N];
  logic [7:0]  mAsid[N];
  logic [20:0] mPpn[N];
  logic [1:0]  mPerm[N];
  logic        mUser[N], mDirty[N];
  int          mLast;
  bit          flushNow;
  bit          pendPend;
  logic [29:0] pVpn; logic [7:0] pAsid; logic [20:0] pPpn;
  logic [1:0]  pPerm; logic pUser, pDirty;

  logic expValid, expHit, expFault, expDirty;
  logic [33:0] expPa;
  int nChecks = 0, nFail = 0;

  function automatic int findMatch(input logic [29:0] v, input logic [7:0] a);
    for (int i = 0; i < N; i++) if (mVal[i] && mVpn[i] == v && mAsid[i] == a) return i;
    return -1;
  endfunction

  task automatic idle();
    lookupValid = 0; lookupVa = '0; lookupAsid = '0; lookupAccess = 2'd0; lookupKernel = 0;
    fillValid = 0; fillVpn = '0; fillAsid = '0; fillPpn = '0; fillPerm = 2'd0;
    fillUser = 0; fillDirty = 0; flushAll = 0; flushAsidValid = 0; flushAsid = '0;
    expValid = 0; expHit = 0; expFault = 0; expDirty = 0; expPa = '0; flushNow = 0;
  endtask

  task automatic check(input string req);
    nChecks++;
    if (respValid !== expValid || respHit !== expHit || respFault !== expFault ||
        respDirty !== expDirty || respPa !== expPa) begin
      nFail++;
      $display("FAIL %s: got v=%b h=%b f=%b d=%b pa=%h, expected v=%b h=%b f=%b d=%b pa=%h",
               req, respValid, respHit, respFault, respDirty, respPa,
               expValid, expHit, expFault, expDirty, expPa);
    end
  endtask

  task automatic endCycle(input string req);
    @(negedge clk);
    check(req);
    idle();
  endtask

  task automatic prepLookup(input logic [29:0] v, input logic [12:0] off, input logic [7:0] a,
                            input logic [1:0] acc, input logic kern);
    int m;
    bit ok;
    lookupValid = 1; lookupVa = {v, off}; lookupAsid = a; lookupAccess = acc; lookupKernel = kern;
    expValid = 1; expHit = 0; expFault = 0; expDirty = 0; expPa = '0;
    m = findMatch(v, a);
    if (m >= 0) begin
      mLast = m;
      case (acc)
        2'd0: ok = (mPerm[m] == 2'd0) || (mPerm[m] == 2'd1);
        2'd1: ok = (mPerm[m] == 2'd1);
        2'd2: ok = (mPerm[m] == 2'd2);
        default: ok = 0;
      endcase
      if (!kern && !mUser[m]) ok = 0;
      if (!ok) expFault = 1;
      else if (acc == 2'd1 && !mDirty[m]) expDirty = 1;
      else begin expHit = 1; expPa = {mPpn[m], off}; end
    end
  endtask

  task automatic prepFill(input logic [29:0] v, input logic [7:0] a, input logic [20:0] p,
                          input logic [1:0] perm, input logic u, input logic d);
    int idx;
    fillValid = 1; fillVpn = v; fillAsid = a; fillPpn = p; fillPerm = perm; fillUser = u; fillDirty = d;
    if (flushNow) return;
    idx = findMatch(v, a);
    if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!mVal[i]) idx = i;
    if (idx < 0) begin
      pendPend = 1; pVpn = v; pAsid = a; pPpn = p; pPerm = perm; pUser = u; pDirty = d;
      return;
    end
    mVal[idx] = 1; mVpn[idx] = v; mAsid[idx] = a; mPpn[idx] = p;
    mPerm[idx] = perm; mUser[idx] = u; mDirty[idx] = d; mLast = idx;
  endtask

  task automatic prepFlushAll();
    flushAll = 1; flushNow = 1;
    for (int i = 0; i < N; i++) mVal[i] = 0;
  endtask

  task automatic prepFlushAsid(input logic [7:0] a);
    flushAsidValid = 1; flushAsid = a; flushNow = 1;
    for (int i = 0; i < N; i++) if (mAsid[i] == a) mVal[i] = 0;
  endtask

  // find which resident page a random eviction removed
  task automatic probeVictim(input int lastBefore);
    int missing, nMiss;
    missing = -1; nMiss = 0;
    for (int i = 0; i < N; i++) begin
      if (mVal[i]) begin
        lookupValid = 1; lookupVa = {mVpn[i], 13'h0}; lookupAsid = mAsid[i];
        lookupAccess = 2'd0; lookupKernel = 1;
        @(negedge clk);
        if (!(respHit || respFault || respDirty)) begin nMiss++; missing = i; end
        else mLast = i;
        idle();
      end
    end
    nChecks++;
    if (nMiss != 1) begin
      nFail++;
      $display("FAIL R7: evictions seen %0d, expected 1", nMiss);
    end
    nChecks++;
    if (missing == lastBefore) begin
      nFail++;
      $display("FAIL R8: victim slot %0d, expected any slot but %0d", missing, lastBefore);
    end
    if (missing >= 0) begin
      mVpn[missing] = pVpn; mAsid[missing] = pAsid; mPpn[missing] = pPpn;
      mPerm[missing] = pPerm; mUser[missing] = pUser; mDirty[missing] = pDirty;
    end
    pendPend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R2: watchdog expired, got hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mVal[i] = 0; mVpn[i] = '0; mAsid[i] = '0; mPpn[i] = '0; mPerm[i] = '0; mUser[i] = 0; mDirty[i] = 0;
    end
    mLast = 0; pendPend = 0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    endCycle("R2 reset idle");
    prepLookup(30'd5, 13'h10, 8'd1, 2'd0, 1); endCycle("R2 empty miss");

    prepFill(30'd10, 8'd1, 21'h111, 2'd0, 1, 0); endCycle("R7 fill");
    prepFill(30'd11, 8'd1, 21'h222, 2'd1, 1, 0); endCycle("R7 fill");
    prepFill(30'd12, 8'd1, 21'h333, 2'd2, 0, 0); endCycle("R7 fill");
    prepFill(30'd13, 8'd1, 21'h444, 2'd1, 1, 1); endCycle("R7 fill");
    prepFill(30'd10, 8'd2, 21'h555, 2'd1, 0, 1); endCycle("R7 fill");
    prepFill(30'd14, 8'd3, 21'h666, 2'd1, 1, 1); endCycle("R7 fill");

    prepLookup(30'd10, 13'h1abc, 8'd1, 2'd0, 0); endCycle("R3 read hit pa");
    prepLookup(30'd10, 13'h0004, 8'd1, 2'd1, 0); endCycle("R6 fault beats dirty");
    prepLookup(30'd10, 13'h0004, 8'd1, 2'd2, 0); endCycle("R4 fetch of read-only");
    prepLookup(30'd11, 13'h0008, 8'd1, 2'd1, 0); endCycle("R6 clean write");
    prepLookup(30'd11, 13'h1fff, 8'd1, 2'd0, 0); endCycle("R4 read of read-write");
    prepLookup(30'd12, 13'h0020, 8'd1, 2'd2, 1); endCycle("R4 fetch-only kernel");
    prepLookup(30'd12, 13'h0020, 8'd1, 2'd2, 0); endCycle("R5 user on kernel page");
    prepLookup(30'd12, 13'h0020, 8'd1, 2'd0, 1); endCycle("R4 read of fetch-only");
    prepLookup(30'd13, 13'h0100, 8'd1, 2'd1, 0); endCycle("R6 dirty write hit");
    prepLookup(30'd10, 13'h0040, 8'd2, 2'd0, 0); endCycle("R5 user fault");
    prepLookup(30'd10, 13'h0040, 8'd2, 2'd0, 1); endCycle("R2 asid select");
    prepLookup(30'd10, 13'h0040, 8'd3, 2'd0, 1); endCycle("R2 asid mismatch miss");

    prepFill(30'd11, 8'd1, 21'h777, 2'd1, 1, 1); endCycle("R7 refill in place");
    prepLookup(30'd11, 13'h0002, 8'd1, 2'd1, 0); endCycle("R7 refill visible");

    prepLookup(30'd15, 13'h0, 8'd1, 2'd0, 1);
    prepFill(30'd15, 8'd1, 21'h0aa, 2'd0, 1, 1); endCycle("R11 lookup sees old");
    prepLookup(30'd15, 13'h0, 8'd1, 2'd0, 1); endCycle("R11 fill then hit");

    prepLookup(30'd10, 13'h0, 8'd1, 2'd0, 1);
    prepFlushAsid(8'd1);
    prepFill(30'd20, 8'd3, 21'h0bb, 2'd1, 1, 1); endCycle("R11 lookup during flush");
    prepLookup(30'd10, 13'h0, 8'd1, 2'd0, 1); endCycle("R10 flushed asid");
    prepLookup(30'd13, 13'h0, 8'd1, 2'd1, 1); endCycle("R10 flushed asid");
    prepLookup(30'd10, 13'h0, 8'd2, 2'd0, 1); endCycle("R10 other asid kept");
    prepLookup(30'd14, 13'h0, 8'd3, 2'd0, 1); endCycle("R10 other asid kept");
    prepLookup(30'd20, 13'h0, 8'd3, 2'd0, 1); endCycle("R11 fill dropped");

    prepFlushAll(); endCycle("R9 flush");
    prepLookup(30'd10, 13'h0, 8'd2, 2'd0, 1); endCycle("R9 all gone");
    prepLookup(30'd14, 13'h0, 8'd3, 2'd0, 1); endCycle("R9 all gone");

    for (int i = 0; i < N; i++) begin
      prepFill(30'(100 + i), 8'd1, 21'(500 + i), 2'd1, 1, 1); endCycle("R1 fill");
    end
    for (int i = 0; i < N; i++) begin
      prepLookup(30'(100 + i), 13'(i), 8'd1, 2'd0, 0); endCycle("R1 all resident");
    end

    for (int j = 0; j < 20; j++) begin
      int k;
      k = (j * 7 + 3) % N;
      prepLookup(mVpn[k], 13'h0, mAsid[k], 2'd0, 1); endCycle("R8 touch");
      prepFill(30'(1000 + j), 8'd1, 21'(600 + j), 2'd1, 1, 1); endCycle("R7 replace");
      probeVictim(k);
      prepLookup(30'(1000 + j), 13'h5, 8'd1, 2'd0, 0); endCycle("R7 new entry hit");
    end

    endCycle("R2 idle");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule